// File: doc/BRIEF.md
# Prescaled 8-bit Reload Down-Timer

This block is an 8-bit down-counter whose count steps are enables drawn from the peripheral clock through a power-of-two prescaler. The prescaler divides by anything from 1 to 16384, and the divide ratio is chosen by a 4-bit select code. Software-style write strobes set the select code, a repeat/one-shot mode bit, an 8-bit reload value and a run/stop control. A separate preset strobe copies the reload value into the counter.

When a count enable arrives while the counter holds zero, the block raises a one-cycle underflow pulse and reloads the counter. In repeat mode it then keeps counting, so it gives periodic pulses of (reload + 1) count ticks. In one-shot mode it reloads and then clears its own run control, which gives exactly one pulse per start. The prescaler is held at zero while the timer is stopped. The first tick after a start therefore comes a full division period later.

Top module: `pdt_top`

## Requirements
- R1: After synchronous reset, count_o is 0, running_o is 0, uf_o is 0 and div_o is 0 (divide by 1). The mode is repeat and the stored reload value is 0.
- R2: With select code k (0 to 14), a count tick occurs once every 2^k peripheral cycles while running. The first tick comes on the 2^k-th running cycle after a start. Two ticks are never adjacent when k is not 0.
- R3: Select code 15 is reserved and yields no count ticks. The counter holds and no underflow pulse occurs while running with it.
- R4: A division-select write takes effect when running_o is 0. While running_o is 1 the write is ignored, and div_o keeps its value.
- R5: Repeat mode is mode bit 0. A tick while the counter is 0 reloads it and counting continues, so underflow pulses are (reload + 1) × 2^k cycles apart.
- R6: One-shot mode is mode bit 1. The first underflow reloads the counter and clears running_o on the same edge, so one pulse occurs per start.
- R7: A preset strobe loads the stored reload value into the counter on the next edge, whether the timer is running or stopped.
- R8: A preset strobe in the same cycle as an underflow condition gives only the preset. No underflow pulse is produced.
- R9: uf_o is one cycle high in the cycle in which count_o first shows the reloaded value after an underflow. It is never high for two adjacent cycles when the select code is not 0.
- R10: Writing run 0 stops the timer. The count holds, no pulses occur and the prescaler is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Division-select write strobe |
| div_wdata | input | 4 | Division select code (2^code, 15 reserved) |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 1 | 0 repeat, 1 one-shot |
| reload_wr | input | 1 | Reload value write strobe |
| reload_wdata | input | 8 | Reload value |
| run_wr | input | 1 | Run control write strobe |
| run_wdata | input | 1 | 1 start, 0 stop |
| preset | input | 1 | Timer-reset strobe: load reload into counter |
| count_o | output | 8 | Current counter value |
| running_o | output | 1 | Run control state |
| div_o | output | 4 | Current division select code |
| uf_o | output | 1 | Underflow pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 14-stage prescaler and a 4-bit select. The full select range is therefore reachable. This covers the slowest ratio, code 14, whose pulse spacing is measured at 16384 cycles. It also covers the reserved code 15, just above the prescaler's length. A reload of 0 at divide-by-1 gives an underflow condition every cycle, and that case is used to collide a preset with an underflow.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic {
    MODE_REPEAT  = 1'b0,
    MODE_ONESHOT = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int PRE_W = 14,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int TAPS = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [TAPS-1:0]  tap;

  // Free-running while the timer runs, held at zero while stopped.
  always_ff @(posedge clk) begin
    if (rst || !run_i) pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;
  end

  // One tap per select code: code k fires when the low k bits wrap.
  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      if (k == 0) begin : g_div1
        assign tap[k] = 1'b1;
      end else if (k <= PRE_W) begin : g_divk
        assign tap[k] = &pre_q[k-1:0];
      end else begin : g_rsvd
        assign tap[k] = 1'b0;
      end
    end
  endgenerate

  assign tick_o = run_i & tap[sel_i];

  assert_reserved_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(sel_i) > PRE_W) |-> !tick_o);

  assert_ticks_spaced_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && sel_i != '0) |=> !tick_o);
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             preset_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o,
  output logic             uf_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             uf_q;

  // Preset wins over an underflow in the same cycle.
  assign uf_evt_o = tick_i && (cnt_q == '0) && !preset_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= uf_evt_o;
      if (preset_i)
        cnt_q <= reload_i;
      else if (tick_i)
        cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = uf_q;

  assert_preset_loads_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(preset_i)) |-> (cnt_q == $past(reload_i)));

  assert_preset_masks_uf_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(preset_i)) |-> !uf_q);

  assert_uf_after_zero_R9: assert property (@(posedge clk) disable iff (rst)
    uf_q |-> ($past(tick_i) && $past(cnt_q) == '0 && cnt_q == $past(reload_i)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !preset_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
  import pdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_wr_i,
  input  logic [SEL_W-1:0] div_wdata_i,
  input  logic             mode_wr_i,
  input  logic             mode_wdata_i,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  input  logic             run_wr_i,
  input  logic             run_wdata_i,
  input  logic             uf_evt_i,
  output logic [SEL_W-1:0] sel_o,
  output tmr_mode_e        mode_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             run_o
);
  logic [SEL_W-1:0] sel_q;
  tmr_mode_e        mode_q;
  logic [CNT_W-1:0] reload_q;
  logic             run_q;
  logic             auto_stop;

  assign auto_stop = uf_evt_i && (mode_q == MODE_ONESHOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      mode_q   <= MODE_REPEAT;
      reload_q <= '0;
      run_q    <= 1'b0;
    end else begin
      if (div_wr_i && !run_q) sel_q <= div_wdata_i;
      if (mode_wr_i)          mode_q <= tmr_mode_e'(mode_wdata_i);
      if (reload_wr_i)        reload_q <= reload_wdata_i;
      if (run_wr_i)           run_q <= run_wdata_i;
      else if (auto_stop)     run_q <= 1'b0;
    end
  end

  assign sel_o    = sel_q;
  assign mode_o   = mode_q;
  assign reload_o = reload_q;
  assign run_o    = run_q;

  assert_div_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && div_wr_i) |=> $stable(sel_q));

  assert_oneshot_halts_R6: assert property (@(posedge clk) disable iff (rst)
    (uf_evt_i && mode_q == MODE_ONESHOT && !run_wr_i) |=> !run_q);

  assert_repeat_continues_R5: assert property (@(posedge clk) disable iff (rst)
    (uf_evt_i && mode_q == MODE_REPEAT && !run_wr_i) |=> run_q);
endmodule

// File: rtl/pdt_top.sv
module pdt_top
  import pdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4,
  parameter int PRE_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_wr,
  input  logic [SEL_W-1:0] div_wdata,
  input  logic             mode_wr,
  input  logic             mode_wdata,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_wdata,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             preset,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic [SEL_W-1:0] div_o,
  output logic             uf_o
);
  logic [SEL_W-1:0] sel;
  tmr_mode_e        mode;
  logic [CNT_W-1:0] reload;
  logic             run;
  logic             tick;
  logic             uf_evt;

  pdt_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .div_wr_i(div_wr), .div_wdata_i(div_wdata),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .reload_wr_i(reload_wr), .reload_wdata_i(reload_wdata),
    .run_wr_i(run_wr), .run_wdata_i(run_wdata),
    .uf_evt_i(uf_evt),
    .sel_o(sel), .mode_o(mode), .reload_o(reload), .run_o(run)
  );

  pdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(run), .sel_i(sel), .tick_o(tick)
  );

  pdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .preset_i(preset),
    .reload_i(reload), .cnt_o(count_o), .uf_o(uf_o), .uf_evt_o(uf_evt)
  );

  assign running_o = run;
  assign div_o     = sel;

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    (uf_o && div_o != '0) |=> !uf_o);
endmodule

// File: tb/pdt_top_bench.sv
module pdt_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_wr = 0, mode_wr = 0, reload_wr = 0, run_wr = 0, preset = 0;
  logic [3:0] div_wdata = 0;
  logic       mode_wdata = 0, run_wdata = 0;
  logic [7:0] reload_wdata = 0;
  logic [7:0] count_o;
  logic       running_o, uf_o;
  logic [3:0] div_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit started = 0;
  bit done = 0;

  // behavioural model state
  int m_cnt, m_rel, m_div, m_el;
  bit m_run, m_mode, m_uf;

  always #4 clk = ~clk;

  pdt_top u_pdt_top (
    .clk(clk), .rst(rst),
    .div_wr(div_wr), .div_wdata(div_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .reload_wr(reload_wr), .reload_wdata(reload_wdata),
    .run_wr(run_wr), .run_wdata(run_wdata),
    .preset(preset),
    .count_o(count_o), .running_o(running_o), .div_o(div_o), .uf_o(uf_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_div = 0; m_el = 0;
      m_run = 0; m_mode = 0; m_uf = 0;
    end else begin
      int per;
      bit tk, ev;
      per = 1 << m_div;
      tk  = m_run && (m_div <= 14) && ((m_el % per) == per - 1);
      ev  = tk && (m_cnt == 0) && !preset;
      m_uf = ev;
      if (preset)  m_cnt = m_rel;
      else if (tk) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
      m_el = m_run ? (m_el + 1) % 16384 : 0;
      if (div_wr && !m_run) m_div = div_wdata;
      if (run_wr)                m_run = run_wdata;
      else if (ev && m_mode)     m_run = 0;
      if (mode_wr)   m_mode = mode_wdata;
      if (reload_wr) m_rel = reload_wdata;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (count_o !== m_cnt[7:0] || running_o !== m_run || uf_o !== m_uf ||
          div_o !== m_div[3:0]) begin
        fails++;
        $display("FAIL %s model: cnt=%0d run=%0b uf=%0b div=%0d expected cnt=%0d run=%0b uf=%0b div=%0d",
                 cur_req, count_o, running_o, uf_o, div_o, m_cnt, m_run, m_uf, m_div);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic w_div(int v);
    div_wr = 1; div_wdata = v[3:0]; @(negedge clk); div_wr = 0;
  endtask
  task automatic w_mode(int v);
    mode_wr = 1; mode_wdata = v[0]; @(negedge clk); mode_wr = 0;
  endtask
  task automatic w_reload(int v);
    reload_wr = 1; reload_wdata = v[7:0]; @(negedge clk); reload_wr = 0;
  endtask
  task automatic w_run(int v);
    run_wr = 1; run_wdata = v[0]; @(negedge clk); run_wr = 0;
  endtask
  task automatic w_preset();
    preset = 1; @(negedge clk); preset = 0;
  endtask

  task automatic cfg(int dv, int md, int rl);
    w_run(0); w_div(dv); w_mode(md); w_reload(rl); w_preset(); w_run(1);
  endtask

  task automatic gap(output int n);
    int guard = 0;
    while (!uf_o && guard < 70000) begin @(negedge clk); guard++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!uf_o && n < 70000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int g, n, pulses, hold;
    int codes[5] = '{0, 1, 3, 7, 14};
    idle(3);
    rst = 0;
    idle(1);
    cur_req = "R1";
    check("R1 count", count_o, 0);
    check("R1 running", running_o, 0);
    check("R1 div", div_o, 0);
    check("R1 uf", uf_o, 0);

    // R2: sweep of division ratios
    cur_req = "R2";
    foreach (codes[i]) begin
      int rl = (codes[i] == 14) ? 0 : 1;
      cfg(codes[i], 0, rl);
      gap(g);
      check($sformatf("R2 gap code %0d", codes[i]), g, (1 << codes[i]) * (rl + 1));
    end

    // R2/R5: full first period after start, then repeat spacing
    cur_req = "R5";
    cfg(2, 0, 3);
    n = 1;
    while (!uf_o && n < 1000) begin @(negedge clk); n++; end
    check("R2 first pulse latency", n, 17);
    gap(g);
    check("R5 repeat gap", g, 16);
    check("R5 still running", running_o, 1);
    check("R9 count shows reload at pulse", count_o, 3);

    // R6: one-shot
    cur_req = "R6";
    cfg(0, 1, 2);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (uf_o) pulses++; end
    check("R6 single pulse", pulses, 1);
    check("R6 halted", running_o, 0);
    check("R6 reloaded", count_o, 2);

    // R3/R4: reserved code and frozen select
    cur_req = "R3";
    cfg(15, 0, 5);
    pulses = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (uf_o) pulses++; end
    check("R3 count held", count_o, 5);
    check("R3 no pulses", pulses, 0);
    cur_req = "R4";
    w_div(3);
    idle(1);
    check("R4 select unchanged while running", div_o, 15);
    w_run(0);
    w_div(3);
    check("R4 select taken while stopped", div_o, 3);

    // R8: preset colliding with underflow
    cur_req = "R8";
    cfg(0, 0, 0);
    idle(5);
    check("R8 pulses each cycle", uf_o, 1);
    w_preset();
    check("R8 no pulse on preset", uf_o, 0);
    check("R8 count preset", count_o, 0);
    idle(1);
    check("R8 pulses resume", uf_o, 1);

    // R7: preset while running and while stopped
    cur_req = "R7";
    cfg(0, 0, 50);
    idle(10);
    w_preset();
    check("R7 preset while running", count_o, 50);
    w_run(0);
    w_reload(9);
    w_preset();
    check("R7 preset while stopped", count_o, 9);

    // R10: stop holds
    cur_req = "R10";
    cfg(1, 0, 100);
    idle(10);
    w_run(0);
    hold = count_o;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (uf_o) pulses++; end
    check("R10 count held", count_o, hold);
    check("R10 no pulses", pulses, 0);
    check("R10 stopped", running_o, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 190000);
    done = 1;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule